// File: doc/BRIEF.md
# Fixed-Point Incremental PI Compensator

This block is a discrete-time proportional-integral controller that works entirely in integers. It is meant for digitally controlled power-conversion loops. Each accepted sample strobe brings in one signed error sample, taken as the reference minus the sensed converter code. The block adds a velocity-form increment to a wide internal accumulator. It then presents that accumulator divided by a power of two as the control output.

The proportional gain, the integral gain, the post-scale shift and both output limits are inputs that may change at run time. One instance can therefore act as a slow output-voltage compensator, for example gains 16384/26 with a divide by 4096, or gains 600/1 with a divide by 256. Another instance can act as a fast inductor-current compensator, for example gains 48/8 with a divide by 64, writing a PWM compare value capped near 1862 of a 1920-count period.

The accumulator is clamped to the output limits scaled up by the divisor. This keeps it from winding up while the output is saturated. The accumulator is kept at full precision, and only its shifted copy leaves the block, so truncation error does not build up from sample to sample.

Top module: `pi_incr_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `ctl_out` is 0, `out_vld` is 0, and the stored previous error and the accumulator are 0.
- R2: An update happens only in a cycle where `smp_stb` and `en` are both 1. `out_vld` is 1 in exactly the cycle after such a strobe and 0 otherwise.
- R3: Each update adds `kp_gain*(e(n) - e(n-1)) + ki_gain*e(n)` to the accumulator. Both gains are unsigned. The error is a two's-complement signed value.
- R4: The previous error e(n-1) is replaced by the current `err_in` only on an accepted strobe.
- R5: `ctl_out` equals the accumulator arithmetically shifted right by `post_shift`, which rounds toward negative infinity. For example, an accumulator of -1 with a shift of 2 gives -1, and -5 gives -2.
- R6: The accumulator keeps every bit below the shift. With `ki_gain`=1, `kp_gain`=0 and a shift of 6, sixty-four error samples of +1 give an output of 0 for the first 63 updates and 1 on the 64th.
- R7: After each update, the accumulator lies within [`lim_lo`·2^shift, `lim_hi`·2^shift]. The output therefore lies within [`lim_lo`, `lim_hi`]. `lim_lo` must not exceed `lim_hi`.
- R8: Because of the clamp in R7, a reversal of the error takes the output out of saturation on the very next update. It does not first have to unwind any excess accumulation.
- R9: A strobe while `en` is 0 changes neither the output nor the internal state, and `out_vld` stays 0.
- R10: A change of gains or shift between strobes takes effect at the next accepted strobe. The accumulator is not rescaled, so a new shift applies directly to the accumulator value held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Enable; strobes are ignored while 0 |
| smp_stb | input | 1 | Single-cycle sample strobe |
| err_in | input | EW | Signed error sample |
| kp_gain | input | KW | Unsigned proportional gain |
| ki_gain | input | KW | Unsigned integral gain |
| post_shift | input | SW | Power-of-two post-scale (right-shift amount) |
| lim_hi | input | OW | Signed upper output limit |
| lim_lo | input | OW | Signed lower output limit |
| ctl_out | output | OW | Signed control output |
| out_vld | output | 1 | One-cycle flag that a new output is present |

## Verification
Every result of this block is due one clock after the accepted strobe. This covers the new `ctl_out`, the `out_vld` pulse and the updated accumulator and previous-error state. The bench therefore drives `smp_stb` and `err_in` on a falling edge and reads the output on the next falling edge, just after the rising edge that registered it. The drop of `out_vld` is checked one cycle after that. After a reset release, the bench waits several cycles for the two-stage reset synchronizer before driving any strobe. Effects on hidden state, such as the previous error under a disabled strobe or the accumulator under a shift change, are exposed through the value of `ctl_out` after a later accepted strobe.

// File: rtl/pi_pkg.sv
package pi_pkg;
  typedef enum logic [1:0] {
    SAT_NONE = 2'd0,
    SAT_HI   = 2'd1,
    SAT_LO   = 2'd2
  } sat_e;
endpackage

// File: rtl/pi_err_hist.sv
module pi_err_hist #(
  parameter int EW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ce,
  input  logic signed [EW-1:0] err_in,
  output logic signed [EW:0]   e_diff
);
  logic signed [EW-1:0] e_prev_q;
  logic signed [EW-1:0] e_prev_d;

  always_comb begin
    e_prev_d = e_prev_q;
    if (ce) e_prev_d = err_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) e_prev_q <= '0;
    else        e_prev_q <= e_prev_d;
  end

  assign e_diff = {err_in[EW-1], err_in} - {e_prev_q[EW-1], e_prev_q};

  // R4
  prev_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce |=> (e_prev_q == $past(err_in)));
  // R4
  prev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(e_prev_q));
endmodule

// File: rtl/pi_incr_calc.sv
module pi_incr_calc #(
  parameter int EW = 16,
  parameter int KW = 16,
  parameter int AW = 40
) (
  input  logic signed [EW-1:0] err_in,
  input  logic signed [EW:0]   e_diff,
  input  logic        [KW-1:0] kp_gain,
  input  logic        [KW-1:0] ki_gain,
  output logic signed [AW-1:0] delta
);
  localparam int EXT_K = AW - KW;
  localparam int EXT_E = AW - EW;
  localparam int EXT_D = AW - EW - 1;

  logic signed [AW-1:0] kp_x;
  logic signed [AW-1:0] ki_x;
  logic signed [AW-1:0] d_x;
  logic signed [AW-1:0] e_x;
  logic signed [AW-1:0] p_term;
  logic signed [AW-1:0] i_term;

  always_comb begin
    kp_x   = {{EXT_K{1'b0}}, kp_gain};
    ki_x   = {{EXT_K{1'b0}}, ki_gain};
    d_x    = {{EXT_D{e_diff[EW]}}, e_diff};
    e_x    = {{EXT_E{err_in[EW-1]}}, err_in};
    p_term = kp_x * d_x;
    i_term = ki_x * e_x;
    delta  = p_term + i_term;
  end
endmodule

// File: rtl/pi_acc_clamp.sv
module pi_acc_clamp
  import pi_pkg::*;
#(
  parameter int AW = 40,
  parameter int OW = 16,
  parameter int SW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ce,
  input  logic signed [AW-1:0] delta,
  input  logic signed [OW-1:0] lim_hi,
  input  logic signed [OW-1:0] lim_lo,
  input  logic        [SW-1:0] shift,
  output logic signed [AW-1:0] acc_nxt
);
  localparam int EXT_L = AW - OW;
  localparam int NLIM  = 2;

  logic signed [OW-1:0] lim_raw [NLIM];
  logic signed [AW-1:0] lim_s   [NLIM];
  logic signed [AW-1:0] acc_q;
  logic signed [AW-1:0] acc_d;
  logic signed [AW-1:0] sum;
  sat_e                 sat;

  assign lim_raw[0] = lim_lo;
  assign lim_raw[1] = lim_hi;

  for (genvar g = 0; g < NLIM; g++) begin : g_lim
    assign lim_s[g] = {{EXT_L{lim_raw[g][OW-1]}}, lim_raw[g]} <<< shift;
  end

  always_comb begin
    sum = acc_q + delta;
    if (sum > lim_s[1])      sat = SAT_HI;
    else if (sum < lim_s[0]) sat = SAT_LO;
    else                     sat = SAT_NONE;
    case (sat)
      SAT_HI:  acc_nxt = lim_s[1];
      SAT_LO:  acc_nxt = lim_s[0];
      default: acc_nxt = sum;
    endcase
    acc_d = acc_q;
    if (ce) acc_d = acc_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  // R7
  acc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce |=> ((acc_q <= $past(lim_s[1])) && (acc_q >= $past(lim_s[0]))));
  // R9
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(acc_q));
endmodule

// File: rtl/pi_post_scale.sv
module pi_post_scale #(
  parameter int AW = 40,
  parameter int OW = 16,
  parameter int SW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ce,
  input  logic signed [AW-1:0] acc_nxt,
  input  logic        [SW-1:0] shift,
  input  logic signed [OW-1:0] lim_hi,
  input  logic signed [OW-1:0] lim_lo,
  output logic signed [OW-1:0] ctl_out,
  output logic                 out_vld
);
  logic signed [OW-1:0] out_d;
  logic                 vld_d;

  always_comb begin
    out_d = ctl_out;
    if (ce) out_d = OW'(acc_nxt >>> shift);
    vld_d = ce;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_out <= '0;
      out_vld <= 1'b0;
    end else begin
      ctl_out <= out_d;
      out_vld <= vld_d;
    end
  end

  // R2
  vld_after_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $past(ce));
  // R2
  vld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> !out_vld);
  // R7
  out_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> ((ctl_out <= $past(lim_hi)) && (ctl_out >= $past(lim_lo))));
  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(ctl_out));
endmodule

// File: rtl/pi_incr_ctrl.sv
module pi_incr_ctrl #(
  parameter int EW = 16,
  parameter int KW = 16,
  parameter int OW = 16,
  parameter int SW = 4,
  parameter int AW = 40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 smp_stb,
  input  logic signed [EW-1:0] err_in,
  input  logic        [KW-1:0] kp_gain,
  input  logic        [KW-1:0] ki_gain,
  input  logic        [SW-1:0] post_shift,
  input  logic signed [OW-1:0] lim_hi,
  input  logic signed [OW-1:0] lim_lo,
  output logic signed [OW-1:0] ctl_out,
  output logic                 out_vld
);
  logic [1:0]           rst_sync_q;
  logic                 rst_int_n;
  logic                 ce;
  logic signed [EW:0]   e_diff;
  logic signed [AW-1:0] delta;
  logic signed [AW-1:0] acc_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign ce = smp_stb & en;

  pi_err_hist #(.EW(EW)) u_hist (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .ce     (ce),
    .err_in (err_in),
    .e_diff (e_diff)
  );

  pi_incr_calc #(.EW(EW), .KW(KW), .AW(AW)) u_calc (
    .err_in  (err_in),
    .e_diff  (e_diff),
    .kp_gain (kp_gain),
    .ki_gain (ki_gain),
    .delta   (delta)
  );

  pi_acc_clamp #(.AW(AW), .OW(OW), .SW(SW)) u_acc (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .ce      (ce),
    .delta   (delta),
    .lim_hi  (lim_hi),
    .lim_lo  (lim_lo),
    .shift   (post_shift),
    .acc_nxt (acc_nxt)
  );

  pi_post_scale #(.AW(AW), .OW(OW), .SW(SW)) u_out (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .ce      (ce),
    .acc_nxt (acc_nxt),
    .shift   (post_shift),
    .lim_hi  (lim_hi),
    .lim_lo  (lim_lo),
    .ctl_out (ctl_out),
    .out_vld (out_vld)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_int_n |-> (ctl_out == '0) && !out_vld);
endmodule

// File: tb/test_pi_incr_ctrl.sv
module test_pi_incr_ctrl;
  logic               clk = 1'b0;
  logic               rst_n;
  logic               en;
  logic               smp_stb;
  logic signed [15:0] err_in;
  logic        [15:0] kp_gain;
  logic        [15:0] ki_gain;
  logic        [3:0]  post_shift;
  logic signed [15:0] lim_hi;
  logic signed [15:0] lim_lo;
  logic signed [15:0] ctl_out;
  logic               out_vld;

  int     n_chk  = 0;
  int     n_fail = 0;
  longint m_acc;
  longint m_ep;

  always #10 clk = ~clk;

  pi_incr_ctrl i_pi_incr_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en), .smp_stb(smp_stb), .err_in(err_in),
    .kp_gain(kp_gain), .ki_gain(ki_gain), .post_shift(post_shift),
    .lim_hi(lim_hi), .lim_lo(lim_lo), .ctl_out(ctl_out), .out_vld(out_vld)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; smp_stb = 1'b0; en = 1'b1;
    repeat (3) @(negedge clk);
    chk(ctl_out == 0, "R1 out in reset", longint'(ctl_out), 0);
    chk(out_vld == 1'b0, "R1 vld in reset", longint'(out_vld), 0);
    rst_n = 1'b1;
    m_acc = 0; m_ep = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cfg(input int kp, input int ki, input int sh, input int hi, input int lo);
    kp_gain = 16'(kp); ki_gain = 16'(ki); post_shift = 4'(sh);
    lim_hi = 16'(hi); lim_lo = 16'(lo);
  endtask

  function automatic longint model_out();
    return m_acc >>> post_shift;
  endfunction

  // one accepted strobe; returns the model output and checks the RTL
  task automatic step(input int e, input string req, output longint exp_o);
    longint hs, ls;
    @(negedge clk);
    err_in = 16'(e); smp_stb = 1'b1;
    m_acc = m_acc + longint'(kp_gain) * (longint'(e) - m_ep) + longint'(ki_gain) * longint'(e);
    hs = longint'(lim_hi) <<< post_shift;
    ls = longint'(lim_lo) <<< post_shift;
    if (m_acc > hs) m_acc = hs;
    if (m_acc < ls) m_acc = ls;
    m_ep = e;
    exp_o = model_out();
    @(negedge clk);
    smp_stb = 1'b0;
    chk(longint'(ctl_out) == exp_o, req, longint'(ctl_out), exp_o);
    chk(out_vld == 1'b1, "R2 vld after strobe", longint'(out_vld), 1);
  endtask

  task automatic t_reset();
    do_reset();
    chk(ctl_out == 0, "R1 out after release", longint'(ctl_out), 0);
    chk(out_vld == 1'b0, "R1 vld after release", longint'(out_vld), 0);
  endtask

  task automatic t_voltage_set();
    longint x;
    int errs[6] = '{10, 10, -5, 20, 0, -30};
    do_reset();
    cfg(16384, 26, 12, 4000, -4000);
    foreach (errs[i]) step(errs[i], "R3 voltage set 16384/26/4096", x);
    @(negedge clk);
    chk(out_vld == 1'b0, "R2 vld single pulse", longint'(out_vld), 0);
  endtask

  task automatic t_random_set();
    longint x;
    logic [15:0] lf = 16'hACE1;
    do_reset();
    cfg(600, 1, 8, 20000, -20000);
    for (int i = 0; i < 50; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(int'($signed(lf[11:0])), "R3 set 600/1/256", x);
    end
  endtask

  task automatic t_truncation();
    longint x;
    do_reset();
    cfg(0, 1, 6, 1000, -1000);
    for (int i = 1; i <= 64; i++) begin
      step(1, "R6 accumulate below shift", x);
      if (i == 63) chk(ctl_out == 0, "R6 still 0 at 63", longint'(ctl_out), 0);
    end
    chk(ctl_out == 1, "R6 reaches 1 at 64", longint'(ctl_out), 1);
  endtask

  task automatic t_rounding();
    longint x;
    do_reset();
    cfg(0, 1, 2, 1000, -1000);
    step(-1, "R5 floor of -1/4", x);
    chk(ctl_out == -1, "R5 -1>>>2", longint'(ctl_out), -1);
    step(-4, "R5 floor of -5/4", x);
    chk(ctl_out == -2, "R5 -5>>>2", longint'(ctl_out), -2);
  endtask

  task automatic t_saturation();
    longint x;
    do_reset();
    cfg(0, 8, 6, 1862, 0);
    for (int i = 0; i < 15; i++) step(1000, "R7 drive to cap", x);
    chk(ctl_out == 1862, "R7 capped output", longint'(ctl_out), 1862);
    step(-1, "R8 leave saturation", x);
    chk(ctl_out == 1861, "R8 immediate recovery", longint'(ctl_out), 1861);
    step(-20000, "R7 floor at lim_lo", x);
    chk(ctl_out == 0, "R7 lower cap", longint'(ctl_out), 0);
  endtask

  task automatic t_disabled();
    longint x;
    do_reset();
    cfg(1, 0, 0, 30000, -30000);
    step(7, "R3 proportional step", x);
    @(negedge clk);
    en = 1'b0; err_in = 16'sd100; smp_stb = 1'b1;
    @(negedge clk);
    smp_stb = 1'b0; en = 1'b1;
    chk(ctl_out == 7, "R9 output unchanged", longint'(ctl_out), 7);
    chk(out_vld == 1'b0, "R9 no valid", longint'(out_vld), 0);
    step(7, "R4 previous error kept", x);
    chk(ctl_out == 7, "R4 no step from ignored sample", longint'(ctl_out), 7);
  endtask

  task automatic t_runtime_change();
    longint x;
    do_reset();
    cfg(0, 1, 0, 30000, -30000);
    step(1000, "R10 build accumulator", x);
    ki_gain = 16'd0; post_shift = 4'd3;
    step(1000, "R10 new shift 3", x);
    chk(ctl_out == 125, "R10 1000>>>3", longint'(ctl_out), 125);
    post_shift = 4'd5;
    step(1000, "R10 new shift 5", x);
    chk(ctl_out == 31, "R10 1000>>>5", longint'(ctl_out), 31);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b1; smp_stb = 1'b0; err_in = '0;
    cfg(0, 0, 0, 0, 0);
    t_reset();
    t_voltage_set();
    t_random_set();
    t_truncation();
    t_rounding();
    t_saturation();
    t_disabled();
    t_runtime_change();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule